// File: doc/BRIEF.md
# Multi-Source Sync Strobe Generator

This block issues the one-cycle strobe that starts or realigns frame timing in a time-division duplex controller. Three sources feed it: a periodic internal sync taken from a free-running match counter, a sync input from outside the chip, and a pulse requested by software. Each source has its own enable input, and any mix of them can be active at once. The merged strobe is registered and leaves the block on `sync_out`, which both the frame logic and other devices can use.

The internal counter is as wide as two programmed words, with the low word in the lower half and the high word in the upper half. Build-time parameters remove the internal source or the external source entirely. They also choose whether the external input first passes through a two-flop synchronizer into the core clock domain.

Top module: `sync_strobe_gen`

## Requirements
- R1: While `rst_n` is low, `sync_out` is 0 after every clock edge. The internal counter is held at zero.
- R2: With `en_int` high and match value M, `sync_out` is high for one cycle after every (M+1)-th rising edge counted from the first edge at which `en_int` is sampled high. It is low after all other edges.
- R3: Dropping `en_int` clears the internal counter and stops internal strobes. Raising it again restarts the count from zero, so the first strobe follows the (M+1)-th edge.
- R4: M is `{match_hi, match_lo}`: `match_lo` supplies bits WORD_W-1..0 and `match_hi` supplies bits 2*WORD_W-1..WORD_W.
- R5: With synchronization built in and `en_ext` high, a rising edge on `ext_in` that is first sampled at edge k gives `sync_out` high after edge k+2 only. Holding `ext_in` high gives no further strobes.
- R6: With `en_ext` low, `en_int` low and `soft_kick` low, `sync_out` stays 0 whatever `ext_in` does.
- R7: Each edge at which `soft_kick` is sampled high is one software request. It gives `sync_out` high after that same edge, and the request clears itself.
- R8: Requests from several sources that land in the same cycle merge into a single one-cycle strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous active-low reset |
| en_int | input | 1 | Enable for the internal periodic source |
| en_ext | input | 1 | Enable for the external source |
| soft_kick | input | 1 | Software sync request, one request per cycle high |
| match_lo | input | WORD_W | Low word of the internal match value |
| match_hi | input | WORD_W | High word of the internal match value |
| ext_in | input | 1 | External sync input, may be asynchronous |
| sync_out | output | 1 | Merged one-cycle sync strobe |

## Verification
The bench builds the block with WORD_W set to 3, which gives a 6-bit match counter. With that width, every one of the 64 match values can be swept for two full periods, including 0 (a strobe every cycle) and the all-ones value that depends on the high word. Both sources and the synchronizer are built in. This exposes the exact three-edge latency of the external path, the single pulse for a held-high input, and the collapse of requests from all three sources into one strobe when they land in the same cycle.

// File: rtl/sync_strobe_gen.sv
module sync_strobe_gen #(
  parameter int WORD_W  = 32,
  parameter bit HAS_INT = 1'b1,
  parameter bit HAS_EXT = 1'b1,
  parameter bit EXT_CDC = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en_int,
  input  logic              en_ext,
  input  logic              soft_kick,
  input  logic [WORD_W-1:0] match_lo,
  input  logic [WORD_W-1:0] match_hi,
  input  logic              ext_in,
  output logic              sync_out
);
  localparam int CNT_W = 2 * WORD_W;

  logic [CNT_W-1:0] match;
  logic [CNT_W-1:0] cnt;
  logic             int_fire;
  logic             ext_fire;

  assign match = {match_hi, match_lo};

  generate
    if (HAS_INT) begin : g_int
      always_ff @(posedge clk) begin
        if (!rst_n || !en_int || cnt == match) cnt <= '0;
        else                                   cnt <= cnt + 1'b1;
      end
      assign int_fire = en_int && (cnt == match);
    end else begin : g_no_int
      logic unused_int;
      assign cnt        = '0;
      assign int_fire   = 1'b0;
      assign unused_int = ^{en_int, match};
    end

    if (HAS_EXT) begin : g_ext
      logic ext_s;
      logic ext_prev;
      if (EXT_CDC) begin : g_cdc
        logic s1, s2;
        always_ff @(posedge clk) begin
          if (!rst_n) begin
            s1 <= 1'b0;
            s2 <= 1'b0;
          end else begin
            s1 <= ext_in;
            s2 <= s1;
          end
        end
        assign ext_s = s2;
      end else begin : g_direct
        assign ext_s = ext_in;
      end
      always_ff @(posedge clk) begin
        if (!rst_n) ext_prev <= 1'b0;
        else        ext_prev <= ext_s;
      end
      assign ext_fire = en_ext && ext_s && !ext_prev;
    end else begin : g_no_ext
      logic unused_ext;
      assign ext_fire   = 1'b0;
      assign unused_ext = ^{en_ext, ext_in};
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) sync_out <= 1'b0;
    else        sync_out <= int_fire | ext_fire | soft_kick;
  end
endmodule

// File: rtl/sync_strobe_chk.sv
module sync_strobe_chk #(
  parameter int CNT_W = 64
) (
  input logic             clk,
  input logic             rst_n,
  input logic             en_int,
  input logic             en_ext,
  input logic             soft_kick,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] match,
  input logic             sync_out
);
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(en_int) && !$past(en_ext) && !$past(soft_kick)) |-> !sync_out); // R6
  AST_SOFT_FIRE: assert property (@(posedge clk) disable iff (!rst_n)
    soft_kick |=> sync_out); // R7
  AST_CNT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    !en_int |=> (cnt == '0)); // R3
  AST_INT_FIRE: assert property (@(posedge clk) disable iff (!rst_n)
    (en_int && cnt == match) |=> sync_out); // R2
endmodule

bind sync_strobe_gen sync_strobe_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .en_int(en_int), .en_ext(en_ext),
  .soft_kick(soft_kick), .cnt(cnt), .match(match), .sync_out(sync_out)
);

// File: tb/tb_sync_strobe_gen.sv
`timescale 1ns/1ps
module tb_sync_strobe_gen;
  localparam int WORD_W = 3;
  localparam int NVAL   = 1 << (2 * WORD_W);

  logic clk = 1'b0;
  logic rst_n, en_int, en_ext, soft_kick, ext_in;
  logic [WORD_W-1:0] match_lo, match_hi;
  logic sync_out;
  int total = 0;
  int bad = 0;

  always #4 clk = ~clk;

  sync_strobe_gen #(.WORD_W(WORD_W), .HAS_INT(1'b1), .HAS_EXT(1'b1), .EXT_CDC(1'b1)) dut (
    .clk(clk), .rst_n(rst_n), .en_int(en_int), .en_ext(en_ext), .soft_kick(soft_kick),
    .match_lo(match_lo), .match_hi(match_hi), .ext_in(ext_in), .sync_out(sync_out)
  );

  task automatic chk(input logic exp, input string tag);
    total++;
    if (sync_out !== exp) begin
      bad++;
      $display("FAIL %s: sync_out got=%b exp=%b at %0t", tag, sync_out, exp, $time);
    end
  endtask

  task automatic set_match(input int m);
    match_lo = m[WORD_W-1:0];
    match_hi = m[2*WORD_W-1:WORD_W];
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog: run did not finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; en_int = 1'b0; en_ext = 1'b0; soft_kick = 1'b0; ext_in = 1'b0;
    set_match(0);
    soft_kick = 1'b1;
    repeat (3) @(negedge clk);
    chk(1'b0, "R1 output low in reset");
    soft_kick = 1'b0;
    rst_n = 1'b1;
    @(negedge clk);
    chk(1'b0, "R1 output low after reset");

    // R2 and R4: sweep every match value
    for (int m = 0; m < NVAL; m++) begin
      en_int = 1'b0;
      set_match(m);
      @(negedge clk);
      en_int = 1'b1;
      for (int e = 1; e <= 2 * (m + 1); e++) begin
        @(negedge clk);
        chk((e % (m + 1)) == 0, "R2/R4 internal period");
      end
      en_int = 1'b0;
      @(negedge clk);
      chk(1'b0, "R3 disabled internal silent");
    end

    // R3: disable mid-period, then restart from zero
    set_match(5);
    en_int = 1'b1;
    repeat (3) @(negedge clk);
    en_int = 1'b0;
    for (int e = 0; e < 4; e++) begin
      @(negedge clk);
      chk(1'b0, "R3 internal held off");
    end
    en_int = 1'b1;
    for (int e = 1; e <= 12; e++) begin
      @(negedge clk);
      chk((e % 6) == 0, "R3 restart from zero");
    end
    en_int = 1'b0;
    @(negedge clk);

    // R5: external rising edge through synchronizer
    en_ext = 1'b1;
    ext_in = 1'b1;
    for (int e = 1; e <= 8; e++) begin
      @(negedge clk);
      chk(e == 3, "R5 external edge latency and single pulse");
    end
    ext_in = 1'b0;
    for (int e = 1; e <= 4; e++) begin
      @(negedge clk);
      chk(1'b0, "R5 falling edge silent");
    end

    // R6: external ignored when disabled
    en_ext = 1'b0;
    for (int e = 0; e < 6; e++) begin
      ext_in = ~ext_in;
      @(negedge clk);
      chk(1'b0, "R6 external disabled");
    end
    ext_in = 1'b0;
    repeat (4) @(negedge clk);
    chk(1'b0, "R6 external disabled drain");

    // R7: software requests
    soft_kick = 1'b1;
    @(negedge clk);
    chk(1'b1, "R7 soft pulse");
    soft_kick = 1'b0;
    @(negedge clk);
    chk(1'b0, "R7 soft self clear");
    soft_kick = 1'b1;
    @(negedge clk);
    chk(1'b1, "R7 first of two requests");
    @(negedge clk);
    chk(1'b1, "R7 second of two requests");
    soft_kick = 1'b0;
    @(negedge clk);
    chk(1'b0, "R7 clear after requests");

    // R8: all three sources land on the same cycle
    set_match(3);
    en_ext = 1'b1;
    en_int = 1'b1;
    for (int e = 1; e <= 12; e++) begin
      ext_in    = (e >= 2 && e <= 6);
      soft_kick = (e == 4);
      @(negedge clk);
      chk((e % 4) == 0, "R8 coincident sources merge");
    end
    en_int = 1'b0; en_ext = 1'b0; soft_kick = 1'b0; ext_in = 1'b0;
    @(negedge clk);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule